// File: doc/BRIEF.md
# Binary and Decimal Accumulator ALU

This block is the arithmetic core of an 8-bit accumulator machine. It receives an operation code, the current accumulator, one memory operand byte and the current carry flag. It then produces a new accumulator value and a new flag. Both results are captured in output registers on a load strobe. It handles binary and packed-BCD addition and subtraction, with or without the flag as carry or borrow input. Subtraction comes in two operand orders. The block also does bitwise OR, AND and XOR, and single-bit shifts through the flag.

The flag has one meaning throughout. After an addition it is the carry out. After a subtraction it is the inverse of the borrow, so 1 means the result was not negative. Decimal subtraction with a negative outcome leaves the ten's complement in the accumulator and reports the sign only through the flag. The width is a parameter, and the decimal correction is built once per 4-bit digit.

Top module: `acc_alu`

## Requirements
- R1: While `rstN` is low, `accOut` and `flagOut` are 0.
- R2: When `load` is low at a rising clock edge, `accOut` and `flagOut` keep their values whatever the other inputs do.
- R3: With `load` high, codes 0x00 (add) and 0x01 (add plus `flagIn`) place the low 8 bits of the binary sum in `accOut` on the next edge. They set `flagOut` to 1 exactly when the true sum exceeds 0xFF.
- R4: Codes 0x02/0x03 compute memory minus accumulator and codes 0x04/0x05 compute accumulator minus memory, in binary. The two's-complement difference goes to `accOut`, and `flagOut` is 1 when no borrow occurred and 0 when one did.
- R5: The odd codes among the subtractions (0x03, 0x05, 0x0B, 0x0D) also subtract the inverse of `flagIn` as a borrow. The plain forms (0x02, 0x04, 0x0A, 0x0C) take no borrow in.
- R6: Codes 0x08 (decimal add) and 0x09 (decimal add plus `flagIn`) treat the operands as two packed BCD digits each. They return the BCD sum modulo 100, and set `flagOut` to 1 exactly when the decimal sum exceeds 99.
- R7: Codes 0x0A/0x0B (memory minus accumulator) and 0x0C/0x0D (accumulator minus memory) subtract in decimal. A negative outcome yields the ten's complement with `flagOut` 0; for example, 0x88 minus 0x99 gives 0x89 with flag 0. A non-negative outcome yields the BCD difference with `flagOut` 1; for example, 0x99 minus 0x88 gives 0x11 with flag 1.
- R8: Codes 0x10 (OR), 0x11 (AND) and 0x12 (XOR) combine the accumulator and the memory operand bitwise and leave `flagOut` unchanged.
- R9: Code 0x14 shifts the accumulator right by one. Bit 0 goes to `flagOut` and bit 7 becomes 0.
- R10: Code 0x15 shifts the accumulator left by one. Bit 7 goes to `flagOut` and bit 0 becomes 0.
- R11: Any other code loaded with `load` high leaves `accOut` and `flagOut` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| load | input | 1 | Captures the operation result into the output registers |
| opCode | input | 5 | Operation select |
| accIn | input | DATA_W (8) | Current accumulator value |
| memIn | input | DATA_W (8) | Memory operand byte |
| flagIn | input | 1 | Current carry/borrow flag |
| accOut | output | DATA_W (8) | Registered new accumulator |
| flagOut | output | 1 | Registered new flag |

## Verification
The bench builds the block with the default `DATA_W` of 8, which gives two decimal digits. The inter-digit carry and borrow therefore pass through exactly one digit boundary, and the wrap at 99 and 00 is reachable with ordinary operands. Random decimal operands are drawn as valid BCD. Each expected value comes from integer arithmetic on the decoded values, so the per-digit correction logic is never mirrored.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 5'h00,
    OP_ADC   = 5'h01,
    OP_SBM   = 5'h02,
    OP_SBMB  = 5'h03,
    OP_SBA   = 5'h04,
    OP_SBAB  = 5'h05,
    OP_DADD  = 5'h08,
    OP_DADC  = 5'h09,
    OP_DSBM  = 5'h0A,
    OP_DSBMB = 5'h0B,
    OP_DSBA  = 5'h0C,
    OP_DSBAB = 5'h0D,
    OP_OR    = 5'h10,
    OP_AND   = 5'h11,
    OP_XOR   = 5'h12,
    OP_SHR   = 5'h14,
    OP_SHL   = 5'h15
  } aluOp_e;

  typedef enum logic [1:0] {
    LG_OR  = 2'd0,
    LG_AND = 2'd1,
    LG_XOR = 2'd2
  } logicSel_e;

  typedef struct packed {
    logic      writeAcc;
    logic      writeFlag;
    logic      doArith;
    logic      doDecimal;
    logic      doSub;
    logic      accFirst;
    logic      useFlag;
    logic      doLogic;
    logicSel_e logicSel;
    logic      doShift;
    logic      shiftLeft;
  } aluStrobe_t;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output aluStrobe_t      strb
);

  always_comb begin
    strb = '0;
    strb.logicSel = LG_OR;
    case (opCode)
      OP_ADD, OP_ADC, OP_SBM, OP_SBMB, OP_SBA, OP_SBAB,
      OP_DADD, OP_DADC, OP_DSBM, OP_DSBMB, OP_DSBA, OP_DSBAB: begin
        strb.doArith   = 1'b1;
        strb.doDecimal = opCode[3];
        strb.useFlag   = opCode[0];
        strb.doSub     = (opCode[2:1] != 2'b00);
        strb.accFirst  = opCode[2];
      end
      OP_OR: begin
        strb.doLogic  = 1'b1;
        strb.logicSel = LG_OR;
      end
      OP_AND: begin
        strb.doLogic  = 1'b1;
        strb.logicSel = LG_AND;
      end
      OP_XOR: begin
        strb.doLogic  = 1'b1;
        strb.logicSel = LG_XOR;
      end
      OP_SHR: strb.doShift = 1'b1;
      OP_SHL: begin
        strb.doShift   = 1'b1;
        strb.shiftLeft = 1'b1;
      end
      default: ;
    endcase
    strb.writeAcc  = strb.doArith | strb.doLogic | strb.doShift;
    strb.writeFlag = strb.doArith | strb.doShift;
  end

endmodule

// File: rtl/acc_alu_dp.sv
module acc_alu_dp
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  aluStrobe_t        strb,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] memIn,
  input  logic              flagIn,
  output logic [DATA_W-1:0] accOut,
  output logic              flagOut
);

  localparam int DIGITS = DATA_W / 4;

  // operand order: x is the minuend for subtraction
  logic [DATA_W-1:0] opX, opY;
  always_comb begin
    if (strb.doSub && !strb.accFirst) begin
      opX = memIn;
      opY = accIn;
    end else begin
      opX = accIn;
      opY = memIn;
    end
  end

  // binary path: subtraction as x + ~y + carry, carry = no-borrow
  logic              binCin;
  logic [DATA_W-1:0] binY;
  logic [DATA_W:0]   binSum;
  always_comb begin
    binCin = strb.useFlag ? flagIn : strb.doSub;
    binY   = strb.doSub ? ~opY : opY;
    binSum = {1'b0, opX} + {1'b0, binY} + {{DATA_W{1'b0}}, binCin};
  end

  // decimal path: ripple of per-digit correctors, chain carries carry or borrow
  logic [DIGITS:0]   decChain;
  logic [DATA_W-1:0] decRes;
  assign decChain[0] = strb.useFlag ? (strb.doSub ? ~flagIn : flagIn) : 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : gDigit
    logic [3:0] xd, yd, digOut;
    logic [4:0] raw;
    logic       digCo;
    assign xd = opX[4*g +: 4];
    assign yd = opY[4*g +: 4];
    always_comb begin
      if (strb.doSub) begin
        raw = {1'b0, xd} - {1'b0, yd} - {4'b0, decChain[g]};
        if (raw[4]) begin
          digOut = raw[3:0] - 4'd6;
          digCo  = 1'b1;
        end else begin
          digOut = raw[3:0];
          digCo  = 1'b0;
        end
      end else begin
        raw = {1'b0, xd} + {1'b0, yd} + {4'b0, decChain[g]};
        if (raw > 5'd9) begin
          digOut = raw[3:0] + 4'd6;
          digCo  = 1'b1;
        end else begin
          digOut = raw[3:0];
          digCo  = 1'b0;
        end
      end
    end
    assign decRes[4*g +: 4] = digOut;
    assign decChain[g+1]    = digCo;
  end

  logic decFlag;
  assign decFlag = strb.doSub ? ~decChain[DIGITS] : decChain[DIGITS];

  // logic and shift
  logic [DATA_W-1:0] logicRes;
  always_comb begin
    case (strb.logicSel)
      LG_AND:  logicRes = accIn & memIn;
      LG_XOR:  logicRes = accIn ^ memIn;
      default: logicRes = accIn | memIn;
    endcase
  end

  logic [DATA_W-1:0] shiftRes;
  logic              shiftFlag;
  always_comb begin
    if (strb.shiftLeft) begin
      shiftRes  = {accIn[DATA_W-2:0], 1'b0};
      shiftFlag = accIn[DATA_W-1];
    end else begin
      shiftRes  = {1'b0, accIn[DATA_W-1:1]};
      shiftFlag = accIn[0];
    end
  end

  // result select
  logic [DATA_W-1:0] nextAcc;
  logic              nextFlag;
  always_comb begin
    nextAcc  = logicRes;
    nextFlag = flagOut;
    if (strb.doArith) begin
      nextAcc  = strb.doDecimal ? decRes : binSum[DATA_W-1:0];
      nextFlag = strb.doDecimal ? decFlag : binSum[DATA_W];
    end else if (strb.doShift) begin
      nextAcc  = shiftRes;
      nextFlag = shiftFlag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accOut  <= '0;
      flagOut <= 1'b0;
    end else if (load) begin
      if (strb.writeAcc)  accOut  <= nextAcc;
      if (strb.writeFlag) flagOut <= nextFlag;
    end
  end

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !load |=> ($stable(accOut) && $stable(flagOut))); // R2
  AST_LOGIC_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (load && strb.doLogic) |=> $stable(flagOut)); // R8
  AST_SHR_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (load && strb.doShift && !strb.shiftLeft) |=> (flagOut == $past(accIn[0]) && !accOut[DATA_W-1])); // R9
  AST_SHL_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (load && strb.doShift && strb.shiftLeft) |=> (flagOut == $past(accIn[DATA_W-1]) && !accOut[0])); // R10
  AST_UNUSED_CODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (load && !strb.writeAcc) |=> ($stable(accOut) && $stable(flagOut))); // R11

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] memIn,
  input  logic              flagIn,
  output logic [DATA_W-1:0] accOut,
  output logic              flagOut
);

  aluStrobe_t strb;

  acc_alu_ctrl ctrl_i (
    .opCode (opCode),
    .strb   (strb)
  );

  acc_alu_dp #(.DATA_W(DATA_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .load    (load),
    .strb    (strb),
    .accIn   (accIn),
    .memIn   (memIn),
    .flagIn  (flagIn),
    .accOut  (accOut),
    .flagOut (flagOut)
  );

endmodule

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       load = 1'b0;
  logic [4:0] opCode = '0;
  logic [7:0] accIn = '0;
  logic [7:0] memIn = '0;
  logic       flagIn = 1'b0;
  logic [7:0] accOut;
  logic       flagOut;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;
  logic [7:0] expAcc = '0;
  logic       expFlag = 1'b0;

  always #4 clk = ~clk;

  acc_alu dut_i (
    .clk(clk), .rstN(rstN), .load(load), .opCode(opCode),
    .accIn(accIn), .memIn(memIn), .flagIn(flagIn),
    .accOut(accOut), .flagOut(flagOut)
  );

  function automatic string tagOf(logic [4:0] op);
    case (op)
      5'h00, 5'h01: return "R3";
      5'h02, 5'h04: return "R4";
      5'h03, 5'h05, 5'h0B, 5'h0D: return "R5";
      5'h08, 5'h09: return "R6";
      5'h0A, 5'h0C: return "R7";
      5'h10, 5'h11, 5'h12: return "R8";
      5'h14: return "R9";
      5'h15: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic int bcdVal(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] toBcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  // reference model, updates expAcc/expFlag
  task automatic model(logic [4:0] op, logic [7:0] a, logic [7:0] m, logic f);
    int x, y, r, cb;
    bit dec, sub, accFirst;
    dec = op[3];
    cb  = int'(op[0]);
    case (op)
      5'h00, 5'h01, 5'h08, 5'h09, 5'h02, 5'h03, 5'h04, 5'h05,
      5'h0A, 5'h0B, 5'h0C, 5'h0D: begin
        sub = (op[2:1] != 2'b00);
        accFirst = op[2];
        if (dec) begin
          x = bcdVal(accFirst || !sub ? a : m);
          y = bcdVal(accFirst || !sub ? m : a);
        end else begin
          x = int'(accFirst || !sub ? a : m);
          y = int'(accFirst || !sub ? m : a);
        end
        if (!sub) begin
          r = x + y + (cb != 0 ? int'(f) : 0);
          expFlag = dec ? (r > 99) : (r > 255);
          expAcc  = dec ? toBcd(r % 100) : 8'(r);
        end else begin
          r = x - y - ((cb != 0 && !f) ? 1 : 0);
          expFlag = (r >= 0);
          if (r < 0) r = r + (dec ? 100 : 256);
          expAcc = dec ? toBcd(r) : 8'(r);
        end
      end
      5'h10: expAcc = a | m;
      5'h11: expAcc = a & m;
      5'h12: expAcc = a ^ m;
      5'h14: begin expFlag = a[0]; expAcc = {1'b0, a[7:1]}; end
      5'h15: begin expFlag = a[7]; expAcc = {a[6:0], 1'b0}; end
      default: ;
    endcase
  endtask

  task automatic compare(string tag);
    nChecks++;
    if (accOut !== expAcc) begin
      nFails++;
      $display("FAIL %s acc actual=%h expected=%h", tag, accOut, expAcc);
    end
    nChecks++;
    if (flagOut !== expFlag) begin
      nFails++;
      $display("FAIL %s flag actual=%b expected=%b", tag, flagOut, expFlag);
    end
  endtask

  task automatic runOp(logic [4:0] op, logic [7:0] a, logic [7:0] m, logic f);
    @(negedge clk);
    opCode = op; accIn = a; memIn = m; flagIn = f; load = 1'b1;
    model(op, a, m, f);
    @(posedge clk);
    #1;
    load = 1'b0;
    compare(tagOf(op));
  endtask

  function automatic logic [7:0] rndBcd();
    return {4'($urandom % 10), 4'($urandom % 10)};
  endfunction

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    compare("R1"); // reset state 0/0
    @(negedge clk);
    rstN = 1'b1;

    // R3 binary add corners
    runOp(5'h00, 8'hFF, 8'h01, 1'b0);
    runOp(5'h01, 8'hFE, 8'h01, 1'b1);
    runOp(5'h00, 8'h7F, 8'h80, 1'b1);
    // R4 both orders
    runOp(5'h02, 8'h10, 8'h20, 1'b0);
    runOp(5'h04, 8'h10, 8'h20, 1'b0);
    runOp(5'h04, 8'h55, 8'h55, 1'b0);
    // R5 borrow in from inverted flag
    runOp(5'h05, 8'h20, 8'h10, 1'b0);
    runOp(5'h03, 8'h10, 8'h10, 1'b0);
    runOp(5'h0D, 8'h50, 8'h20, 1'b0);
    runOp(5'h0B, 8'h00, 8'h00, 1'b1);
    // R6 decimal add
    runOp(5'h08, 8'h99, 8'h01, 1'b0);
    runOp(5'h09, 8'h45, 8'h54, 1'b1);
    runOp(5'h08, 8'h38, 8'h29, 1'b0);
    // R7 ten's complement examples
    runOp(5'h0C, 8'h88, 8'h99, 1'b0);
    runOp(5'h0C, 8'h99, 8'h88, 1'b0);
    runOp(5'h0A, 8'h99, 8'h88, 1'b1);
    // R8 logic with flag held (make flag 1 first)
    runOp(5'h00, 8'hF0, 8'h20, 1'b0);
    runOp(5'h10, 8'hA0, 8'h05, 1'b0);
    runOp(5'h11, 8'hF3, 8'h3C, 1'b0);
    runOp(5'h12, 8'hFF, 8'h0F, 1'b0);
    // R9 R10 shifts
    runOp(5'h14, 8'h81, 8'h00, 1'b0);
    runOp(5'h15, 8'h81, 8'h00, 1'b0);
    runOp(5'h15, 8'h7E, 8'h00, 1'b1);
    // R11 unassigned codes
    runOp(5'h06, 8'h12, 8'h34, 1'b1);
    runOp(5'h1F, 8'hAB, 8'hCD, 1'b0);
    runOp(5'h13, 8'h01, 8'h01, 1'b1);

    // R2 no load: inputs wiggle, outputs hold
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      opCode = 5'($urandom % 22); accIn = 8'($urandom); memIn = 8'($urandom);
      flagIn = 1'($urandom);
      @(posedge clk);
      #1;
      compare("R2");
    end

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [4:0] op;
      logic [7:0] a, m;
      op = 5'($urandom % 22);
      if (op[4:3] == 2'b01) begin
        a = rndBcd(); m = rndBcd();
      end else begin
        a = 8'($urandom); m = 8'($urandom);
      end
      runOp(op, a, m, 1'($urandom));
    end

    // R1 reset again mid-run
    @(negedge clk);
    rstN = 1'b0;
    expAcc = '0; expFlag = 1'b0;
    @(posedge clk);
    #1;
    compare("R1");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule